// File: doc/BRIEF.md
# PWM Event Action Unit with Continuous Output Force

This block turns time-base events into two PWM output levels. A separate time base supplies a tick strobe, a zero-event strobe, a period-event strobe, the counter value and the count direction. On every tick the block finds which events are present, picks one action per output from that output's action register, and then drives the output low, drives it high, toggles it or leaves it unchanged. Two compare registers, one per output, produce compare events when the counter matches them while it counts up. Both outputs share the one period that the time base supplies.

Software can hold either output at a fixed level with a continuous force. Writes land in a shadow copy of the force setting. The active copy takes the shadow value at a point that software chooses: at the zero event, at the period event, at either one, or at the next tick. While a force is active it overrides every event action. When the force is released, the output keeps its level until the next event action changes it. All control values are written through a simple register write port.

Top module: `pwm_event_action`

## Requirements
- R1: After reset both outputs are low. Both compare values and both action registers are zero. The force reload point is "zero event" and both force fields are 00.
- R2: Action codes are 00 no change, 01 drive low, 10 drive high and 11 toggle. Outputs change only in a cycle where `tick` is high.
- R3: In each action register, bits [1:0] give the zero-event action, [3:2] the period-event action, [5:4] the compare-A-up action and [9:8] the compare-B-up action. Output A uses register address 2 and output B uses address 3. Compare A is at address 0 and compare B at address 1.
- R4: A compare event fires on a tick when `cnt` equals the compare value and `cnt_up` is 1. There is no compare event while counting down.
- R5: When several events fire on one tick, the action comes from the highest-priority event whose code is not 00. The order from highest to lowest is compare A, compare B, period, zero.
- R6: The action value 0x01A on output A (0x10A on output B) gives normal PWM: high at zero and period, low at the compare match. The values 0x025 and 0x205 give the inverted waveform.
- R7: The shadow force register (address 5) has bits [1:0] for output A and [3:2] for output B. Code 01 forces low, 10 forces high, and codes 00 and 11 both release the output to event control.
- R8: Bits [7:6] of the reload register (address 4) choose when the shadow force becomes active: 00 at a zero event, 01 at a period event, 10 at either event, 11 on any tick. Until then the shadow value has no effect on the outputs.
- R9: In mode 11 a written force level shows on the output after the first tick that follows the write, and not before that tick.
- R10: While a force low or force high is active (including on the tick that loads it), the output holds the forced level whatever the event actions are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick; events and reloads take effect only in tick cycles |
| zero_evt | input | 1 | Counter-at-zero event from the time base |
| prd_evt | input | 1 | Counter-at-period event from the time base |
| cnt | input | W | Time-base counter value |
| cnt_up | input | 1 | 1 while the time base counts up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 cmp A, 1 cmp B, 2 act A, 3 act B, 4 reload, 5 force) |
| wr_data | input | W | Register write data |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
The bench builds the block with the default width W = 16. The bench acts as the time base itself and drives the counter directly, so a short period of seven counts is enough to give full normal and inverted waveforms, compare values that coincide with the zero and period events, and a compare hit while counting down. It tests every reload point of the force, both release codes and the immediate path, each in a few cycles, and checks the tick on which each forced level appears.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

    localparam int unsigned NUM_OUT = 2;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned FRC_W   = 2 * NUM_OUT;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_CMP_A  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CMP_B  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_ACT_A  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_ACT_B  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_FORCE  = 3'd5;

    // action field positions inside an action register
    localparam int unsigned FLD_ZERO_LSB = 0;
    localparam int unsigned FLD_PRD_LSB  = 2;
    localparam int unsigned FLD_CMPA_LSB = 4;
    localparam int unsigned FLD_CMPB_LSB = 8;
    localparam int unsigned RLD_LSB      = 6;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_DIS  = 2'b11
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PRD    = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef struct packed {
        logic cmp_a;
        logic cmp_b;
        logic prd;
        logic zero;
    } evt_t;

    typedef struct packed {
        act_e cmp_a;
        act_e cmp_b;
        act_e prd;
        act_e zero;
    } act_set_t;

    // highest-priority firing event with a non-idle code wins
    function automatic act_e pick_action(input evt_t e, input act_set_t s);
        if (e.cmp_a && s.cmp_a != ACT_NONE) return s.cmp_a;
        if (e.cmp_b && s.cmp_b != ACT_NONE) return s.cmp_b;
        if (e.prd   && s.prd   != ACT_NONE) return s.prd;
        if (e.zero  && s.zero  != ACT_NONE) return s.zero;
        return ACT_NONE;
    endfunction

    function automatic logic apply_action(input act_e a, input logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
    import pwm_evt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [W-1:0]                wr_data,
    input  logic                        tick,
    input  logic                        zero_evt,
    input  logic                        prd_evt,
    output logic [NUM_OUT-1:0][W-1:0]   cmp_val,
    output act_set_t [NUM_OUT-1:0]      acts,
    output logic [FRC_W-1:0]            frc_eff,
    output logic [FRC_W-1:0]            frc_act
);

    logic [NUM_OUT-1:0][W-1:0] cmp_q;
    act_set_t [NUM_OUT-1:0]    act_q;
    rld_e                      rld_q;
    logic [FRC_W-1:0]          frc_shd_q;
    logic [FRC_W-1:0]          frc_act_q;
    logic                      load_now;
    act_set_t                  wr_act;

    // decode an action register write into its event fields
    always_comb begin
        wr_act.zero  = act_e'(wr_data[FLD_ZERO_LSB +: 2]);
        wr_act.prd   = act_e'(wr_data[FLD_PRD_LSB  +: 2]);
        wr_act.cmp_a = act_e'(wr_data[FLD_CMPA_LSB +: 2]);
        wr_act.cmp_b = act_e'(wr_data[FLD_CMPB_LSB +: 2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q     <= '0;
            act_q     <= '0;
            rld_q     <= RLD_ZERO;
            frc_shd_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CMP_A:  cmp_q[0]  <= wr_data;
                ADR_CMP_B:  cmp_q[1]  <= wr_data;
                ADR_ACT_A:  act_q[0]  <= wr_act;
                ADR_ACT_B:  act_q[1]  <= wr_act;
                ADR_RELOAD: rld_q     <= rld_e'(wr_data[RLD_LSB +: 2]);
                ADR_FORCE:  frc_shd_q <= wr_data[FRC_W-1:0];
                default: ;
            endcase
        end
    end

    // reload point for the active force copy
    always_comb begin
        case (rld_q)
            RLD_ZERO:   load_now = tick & zero_evt;
            RLD_PRD:    load_now = tick & prd_evt;
            RLD_EITHER: load_now = tick & (zero_evt | prd_evt);
            default:    load_now = tick;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           frc_act_q <= '0;
        else if (load_now) frc_act_q <= frc_shd_q;
    end

    // on a loading tick the new value already governs the output
    assign frc_eff = load_now ? frc_shd_q : frc_act_q;
    assign frc_act = frc_act_q;
    assign cmp_val = cmp_q;
    assign acts    = act_q;

endmodule

// File: rtl/pwm_evt_chan.sv
module pwm_evt_chan
    import pwm_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  evt_t     evt,
    input  act_set_t acts,
    input  logic [1:0] frc,
    output logic     out
);

    logic out_q;
    logic out_nxt;
    act_e sel_act;
    frc_e frc_mode;

    assign sel_act  = pick_action(evt, acts);
    assign frc_mode = frc_e'(frc);

    always_comb begin
        case (frc_mode)
            FRC_LOW:  out_nxt = 1'b0;
            FRC_HIGH: out_nxt = 1'b1;
            default:  out_nxt = apply_action(sel_act, out_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       out_q <= 1'b0;
        else if (tick) out_q <= out_nxt;
    end

    assign out = out_q;

endmodule

// File: rtl/pwm_event_action.sv
module pwm_event_action
    import pwm_evt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              zero_evt,
    input  logic              prd_evt,
    input  logic [W-1:0]      cnt,
    input  logic              cnt_up,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              out_a,
    output logic              out_b
);

    logic [NUM_OUT-1:0][W-1:0] cmp_val;
    act_set_t [NUM_OUT-1:0]    acts;
    logic [FRC_W-1:0]          frc_eff;
    logic [FRC_W-1:0]          frc_act;
    logic [NUM_OUT-1:0]        cmp_hit;
    logic [NUM_OUT-1:0]        outs;
    evt_t                      evt;

    pwm_evt_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tick     (tick),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt),
        .cmp_val  (cmp_val),
        .acts     (acts),
        .frc_eff  (frc_eff),
        .frc_act  (frc_act)
    );

    // compare detection, up-count only
    for (genvar c = 0; c < NUM_OUT; c++) begin : g_cmp
        assign cmp_hit[c] = cnt_up && (cnt == cmp_val[c]);
    end

    always_comb begin
        evt.cmp_a = cmp_hit[0];
        evt.cmp_b = cmp_hit[1];
        evt.prd   = prd_evt;
        evt.zero  = zero_evt;
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_chan
        pwm_evt_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .evt  (evt),
            .acts (acts[k]),
            .frc  (frc_eff[2*k +: 2]),
            .out  (outs[k])
        );
    end

    assign out_a = outs[0];
    assign out_b = outs[1];

endmodule

// File: rtl/pwm_evt_chk.sv
module pwm_evt_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       out_a,
    input logic       out_b,
    input logic [3:0] frc_eff,
    input logic [3:0] frc_act
);

    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> (!out_a && !out_b)); // R1

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> ($stable(out_a) && $stable(out_b))); // R2

    AST_FORCE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> $stable(frc_act)); // R8

    AST_FORCE_LOW_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && $past(frc_eff[1:0]) == 2'b01) |-> !out_a); // R10

    AST_FORCE_HIGH_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && $past(frc_eff[1:0]) == 2'b10) |-> out_a); // R10

    AST_FORCE_LOW_B: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && $past(frc_eff[3:2]) == 2'b01) |-> !out_b); // R10

    AST_FORCE_HIGH_B: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && $past(frc_eff[3:2]) == 2'b10) |-> out_b); // R10

endmodule

bind pwm_event_action pwm_evt_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .out_a   (out_a),
    .out_b   (out_b),
    .frc_eff (frc_eff),
    .frc_act (frc_act)
);

// File: tb/sim_pwm_event_action.sv
module sim_pwm_event_action;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        zero_evt = 1'b0;
    logic        prd_evt = 1'b0;
    logic [15:0] cnt = '0;
    logic        cnt_up = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_a;
    logic        out_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm_event_action #(.W(16)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .zero_evt(zero_evt), .prd_evt(prd_evt),
        .cnt(cnt), .cnt_up(cnt_up), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_a(out_a), .out_b(out_b)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk2(input string req, input logic ea, input logic eb);
        check(req, "out_a", out_a, ea);
        check(req, "out_b", out_b, eb);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b0;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic t, input logic z, input logic p,
                        input logic [15:0] c, input logic up);
        tick = t; zero_evt = z; prd_evt = p; cnt = c; cnt_up = up;
        @(posedge clk); @(negedge clk);
        tick = 1'b0; zero_evt = 1'b0; prd_evt = 1'b0;
    endtask

    // one up-count period 0..7 with expected outputs per count
    task automatic run_period(input string req, input logic [7:0] ea, input logic [7:0] eb);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, i == 0, i == 7, 16'(i), 1'b1);
            chk2(req, ea[i], eb[i]);
        end
    endtask

    task automatic t_reset;
        chk2("R1", 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 16'd0, 1'b1);   // zero registers: nothing happens
        chk2("R1", 1'b0, 1'b0);
    endtask

    task automatic t_codes;
        wr(3'd2, 16'h000E);                     // zero high, period toggle
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        chk2("R2", 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 16'd7, 1'b1);
        chk2("R2", 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 16'd7, 1'b1);    // no tick: no change
        chk2("R2", 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 16'd7, 1'b1);
        chk2("R3", 1'b1, 1'b0);
        wr(3'd2, 16'h0001);                     // zero low
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        chk2("R3", 1'b0, 1'b0);
    endtask

    task automatic t_pwm_normal;
        wr(3'd0, 16'd3);
        wr(3'd1, 16'd5);
        wr(3'd2, 16'h001A);
        wr(3'd3, 16'h010A);
        run_period("R6", 8'b1000_0111, 8'b1001_1111);
        step(1'b1, 1'b0, 1'b0, 16'd3, 1'b0);    // match while counting down
        chk2("R4", 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);    // same match counting up
        chk2("R4", 1'b0, 1'b1);
    endtask

    task automatic t_pwm_inverted;
        wr(3'd2, 16'h0025);
        wr(3'd3, 16'h0205);
        run_period("R6", 8'b0111_1000, 8'b0110_0000);
    endtask

    task automatic t_priority;
        wr(3'd0, 16'd4);
        wr(3'd1, 16'd4);
        wr(3'd2, 16'h0239);                     // zero low, prd high, cmpA toggle, cmpB high
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        check("R5", "out_a", out_a, 1'b0);
        step(1'b1, 1'b1, 1'b1, 16'd4, 1'b1);    // compare A toggle wins
        check("R5", "out_a", out_a, 1'b1);
        step(1'b1, 1'b1, 1'b1, 16'd4, 1'b1);
        check("R5", "out_a", out_a, 1'b0);
        wr(3'd2, 16'h0209);                     // compare A idle: compare B high wins
        step(1'b1, 1'b1, 1'b1, 16'd4, 1'b1);
        check("R5", "out_a", out_a, 1'b1);
        wr(3'd2, 16'h0009);
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        check("R5", "out_a", out_a, 1'b0);
        step(1'b1, 1'b1, 1'b1, 16'd4, 1'b1);    // period beats zero
        check("R5", "out_a", out_a, 1'b1);
        wr(3'd2, 16'h0001);
        step(1'b1, 1'b1, 1'b1, 16'd4, 1'b1);    // only zero left
        check("R5", "out_a", out_a, 1'b0);
    endtask

    task automatic t_force;
        wr(3'd0, 16'd3);
        wr(3'd1, 16'd5);
        wr(3'd2, 16'h001A);
        wr(3'd3, 16'h010A);
        // reload at period
        wr(3'd4, 16'h0040);
        wr(3'd5, 16'h0009);                     // A low, B high in shadow
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        chk2("R8", 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);
        chk2("R8", 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1, 16'd7, 1'b1);    // loads; period high overridden
        chk2("R10", 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        chk2("R10", 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 16'd5, 1'b1);
        chk2("R10", 1'b0, 1'b1);
        wr(3'd5, 16'h0000);
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);    // release still in shadow
        chk2("R8", 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1, 16'd7, 1'b1);
        chk2("R7", 1'b1, 1'b1);
        // reload at zero
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'h0006);                     // A high, B low
        step(1'b1, 1'b0, 1'b1, 16'd7, 1'b1);
        chk2("R8", 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);
        chk2("R8", 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        chk2("R7", 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);
        chk2("R10", 1'b1, 1'b0);
        // reload at either event; code 11 releases
        wr(3'd4, 16'h0080);
        wr(3'd5, 16'h000F);
        step(1'b1, 1'b0, 1'b0, 16'd1, 1'b1);
        chk2("R8", 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 16'd7, 1'b1);
        chk2("R7", 1'b1, 1'b1);
        wr(3'd5, 16'h0005);
        step(1'b1, 1'b1, 1'b0, 16'd0, 1'b1);
        chk2("R8", 1'b0, 1'b0);
        // immediate reload
        wr(3'd4, 16'h00C0);
        wr(3'd5, 16'h000A);
        step(1'b0, 1'b0, 1'b0, 16'd1, 1'b1);
        chk2("R9", 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 16'd1, 1'b1);
        chk2("R9", 1'b1, 1'b1);
        wr(3'd5, 16'h0000);
        step(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);
        chk2("R9", 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_codes();
        t_pwm_normal();
        t_pwm_inverted();
        t_priority();
        t_force();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule